// File: doc/BRIEF.md
# Processor Status Flags and Saved Return Word

This unit holds the sticky status flags of a 36-bit processor and builds the word that a subroutine call stores. Arithmetic, floating-point, divide, stack and interrupt logic elsewhere in the core report one-cycle event strobes. The unit turns these into flag bits. It derives the arithmetic-overflow flag itself, from a mismatch between the carry out of bit 0 and the carry out of bit 1. Two trap bits record the cause, and a trap request is raised when traps are enabled.

On a call strobe, the unit captures a 36-bit word. The status flags go in the upper bits, five bits of zero follow, and the low 18 bits hold the address after the call. The flags captured are those held at the start of the call cycle. A restore strobe reloads all flags from a previously saved word. Bits are numbered 0 (most significant) to 35, so word bit n is vector index 35-n.

Top module: `stat_flags_unit`

## Requirements
- R1: After reset, `flags_o`, `save_word_o`, `trap_req_o` and `addr_brk_inh_o` are all zero.
- R2: `flags_o[12:0]` maps word bits 0..12 in this order: [12] overflow, [11] carry-0, [10] carry-1, [9] float overflow, [8] first-part-done, [7] user, [6] user I/O, [5] public, [4] address-failure-inhibit, [3] TRAP2, [2] TRAP1, [1] exponent underflow, [0] divide check. A single carry strobe (`cry0_i` xor `cry1_i`) sets that carry flag, overflow and TRAP1. Both strobes together set both carry flags and nothing else.
- R3: `exp_unf_i` sets exponent underflow, float overflow, overflow and TRAP1. `flt_ovf_i` sets float overflow, overflow and TRAP1. `div_chk_i` sets divide check, overflow and TRAP1.
- R4: `pdl_ovf_i` sets TRAP2. When it coincides with an overflow source, TRAP2 is set and TRAP1 is not, so both trap bits are never set together by events.
- R5: `trap_req_o` is combinational and equals `trap_en_i` AND (the next-state TRAP1 OR TRAP2). It therefore rises in the same cycle as the setting event.
- R6: `intr_mid_i` sets first-part-done.
- R7: `mode_wr_i` loads user, user I/O and public from `mode_i[2]`, `mode_i[1]` and `mode_i[0]`.
- R8: `afi_set_i` sets the inhibit flag, and `addr_brk_inh_o` follows it. `insn_done_i` clears the flag unless `afi_set_i` is also asserted in that cycle.
- R9: Flags set by events stay set through idle cycles.
- R10: `restore_i` loads all 13 flags from `restore_word_i[35:23]` in one cycle and overrides any same-cycle event, mode write or clear.
- R11: In the cycle after `call_i`, `save_word_o` holds the flags in [35:23], zeros in [22:18] and (`call_addr_i`+1) mod 2^18 in [17:0]. It keeps that value until the next call.
- R12: The flags captured by a call are the values held before any event that arrives in the call cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cry0_i | input | 1 | Carry out of bit 0 in an add |
| cry1_i | input | 1 | Carry out of bit 1 in an add |
| flt_ovf_i | input | 1 | Floating overflow event |
| exp_unf_i | input | 1 | Exponent underflow event |
| div_chk_i | input | 1 | Divide check event |
| pdl_ovf_i | input | 1 | Pushdown overflow event |
| intr_mid_i | input | 1 | Interrupt taken after first part of two-part instruction |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_i | input | 3 | New user, user I/O and public levels |
| afi_set_i | input | 1 | Set address-failure-inhibit |
| insn_done_i | input | 1 | Instruction completion strobe |
| trap_en_i | input | 1 | Trap enable |
| call_i | input | 1 | Subroutine call strobe |
| call_addr_i | input | 18 | Address of the call instruction |
| restore_i | input | 1 | Restore flags strobe |
| restore_word_i | input | 36 | Saved word to restore from |
| save_word_o | output | 36 | Packed saved word |
| flags_o | output | 13 | Current flag levels |
| trap_req_o | output | 1 | Trap request |
| addr_brk_inh_o | output | 1 | Address-break inhibit |

## Verification
The hardest cases to reach are those where a call or a restore coincides with a flag-setting event. The call must capture pre-event flags, and the restore must discard the event. From the ports these can only be told apart when both strobes land in the same clock. The bench therefore drives the event and the call or restore on the same falling edge. It then checks both the captured word and the flags left afterward. The same-cycle trap request is sampled before the clock edge, while `flags_o` still shows the old value.

// File: rtl/stat_flags_pkg.sv
package stat_flags_pkg;
  localparam int FLAG_N = 13;
  // vector index = 12 - word bit
  localparam int F_AROV = 12;
  localparam int F_CRY0 = 11;
  localparam int F_CRY1 = 10;
  localparam int F_FOV  = 9;
  localparam int F_FPD  = 8;
  localparam int F_USER = 7;
  localparam int F_UIO  = 6;
  localparam int F_PUB  = 5;
  localparam int F_AFI  = 4;
  localparam int F_TRP2 = 3;
  localparam int F_TRP1 = 2;
  localparam int F_FXU  = 1;
  localparam int F_DCK  = 0;
  typedef logic [FLAG_N-1:0] flag_vec_t;
endpackage

// File: rtl/sf_event_decode.sv
module sf_event_decode
  import stat_flags_pkg::*;
(
  input  logic      cry0_i,
  input  logic      cry1_i,
  input  logic      flt_ovf_i,
  input  logic      exp_unf_i,
  input  logic      div_chk_i,
  input  logic      pdl_ovf_i,
  input  logic      intr_mid_i,
  input  logic      afi_set_i,
  output flag_vec_t set_mask_o
);
  logic ovf_src;

  always_comb begin
    ovf_src    = (cry0_i ^ cry1_i) | flt_ovf_i | exp_unf_i | div_chk_i;
    set_mask_o = '0;
    set_mask_o[F_AROV] = ovf_src;
    set_mask_o[F_CRY0] = cry0_i;
    set_mask_o[F_CRY1] = cry1_i;
    set_mask_o[F_FOV]  = flt_ovf_i | exp_unf_i;
    set_mask_o[F_FXU]  = exp_unf_i;
    set_mask_o[F_DCK]  = div_chk_i;
    set_mask_o[F_FPD]  = intr_mid_i;
    set_mask_o[F_AFI]  = afi_set_i;
    // pushdown cause takes the trap encoding when both coincide
    set_mask_o[F_TRP2] = pdl_ovf_i;
    set_mask_o[F_TRP1] = ovf_src & ~pdl_ovf_i;
  end
endmodule

// File: rtl/sf_flag_reg.sv
module sf_flag_reg
  import stat_flags_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  flag_vec_t set_mask_i,
  input  logic      mode_wr_i,
  input  logic [2:0] mode_i,
  input  logic      insn_done_i,
  input  logic      restore_i,
  input  flag_vec_t restore_flags_i,
  output flag_vec_t flags_q_o,
  output flag_vec_t flags_nxt_o
);
  flag_vec_t flags_q;

  always_comb begin
    flags_nxt_o = flags_q | set_mask_i;
    if (mode_wr_i) begin
      flags_nxt_o[F_USER] = mode_i[2];
      flags_nxt_o[F_UIO]  = mode_i[1];
      flags_nxt_o[F_PUB]  = mode_i[0];
    end
    if (insn_done_i && !set_mask_i[F_AFI]) flags_nxt_o[F_AFI] = 1'b0;
    if (restore_i) flags_nxt_o = restore_flags_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_nxt_o;
  end

  assign flags_q_o = flags_q;
endmodule

// File: rtl/sf_ret_pack.sv
module sf_ret_pack
  import stat_flags_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int WORD_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              call_i,
  input  logic [ADDR_W-1:0] call_addr_i,
  input  flag_vec_t         flags_i,
  output logic [WORD_W-1:0] save_word_o
);
  localparam int PAD_W = WORD_W - FLAG_N - ADDR_W;

  logic [ADDR_W-1:0] ret_addr;
  logic [WORD_W-1:0] word_q;

  assign ret_addr = call_addr_i + ADDR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (call_i) word_q <= {flags_i, {PAD_W{1'b0}}, ret_addr};
  end

  assign save_word_o = word_q;
endmodule

// File: rtl/stat_flags_unit.sv
module stat_flags_unit
  import stat_flags_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int WORD_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cry0_i,
  input  logic              cry1_i,
  input  logic              flt_ovf_i,
  input  logic              exp_unf_i,
  input  logic              div_chk_i,
  input  logic              pdl_ovf_i,
  input  logic              intr_mid_i,
  input  logic              mode_wr_i,
  input  logic [2:0]        mode_i,
  input  logic              afi_set_i,
  input  logic              insn_done_i,
  input  logic              trap_en_i,
  input  logic              call_i,
  input  logic [ADDR_W-1:0] call_addr_i,
  input  logic              restore_i,
  input  logic [WORD_W-1:0] restore_word_i,
  output logic [WORD_W-1:0] save_word_o,
  output logic [FLAG_N-1:0] flags_o,
  output logic              trap_req_o,
  output logic              addr_brk_inh_o
);
  flag_vec_t set_mask;
  flag_vec_t flags_q;
  flag_vec_t flags_nxt;

  sf_event_decode u_dec (
    .cry0_i     (cry0_i),
    .cry1_i     (cry1_i),
    .flt_ovf_i  (flt_ovf_i),
    .exp_unf_i  (exp_unf_i),
    .div_chk_i  (div_chk_i),
    .pdl_ovf_i  (pdl_ovf_i),
    .intr_mid_i (intr_mid_i),
    .afi_set_i  (afi_set_i),
    .set_mask_o (set_mask)
  );

  sf_flag_reg u_reg (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .set_mask_i      (set_mask),
    .mode_wr_i       (mode_wr_i),
    .mode_i          (mode_i),
    .insn_done_i     (insn_done_i),
    .restore_i       (restore_i),
    .restore_flags_i (restore_word_i[WORD_W-1 -: FLAG_N]),
    .flags_q_o       (flags_q),
    .flags_nxt_o     (flags_nxt)
  );

  sf_ret_pack #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_pack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .call_i      (call_i),
    .call_addr_i (call_addr_i),
    .flags_i     (flags_q),
    .save_word_o (save_word_o)
  );

  assign flags_o        = flags_q;
  assign trap_req_o     = trap_en_i & (flags_nxt[F_TRP1] | flags_nxt[F_TRP2]);
  assign addr_brk_inh_o = flags_q[F_AFI];
endmodule

// File: rtl/stat_flags_chk.sv
module stat_flags_chk
  import stat_flags_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int WORD_W = 36
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cry0_i,
  input logic              cry1_i,
  input logic              mode_wr_i,
  input logic              insn_done_i,
  input logic              afi_set_i,
  input logic              trap_en_i,
  input logic              call_i,
  input logic [ADDR_W-1:0] call_addr_i,
  input logic              restore_i,
  input logic [WORD_W-1:0] restore_word_i,
  input logic [WORD_W-1:0] save_word_o,
  input logic [FLAG_N-1:0] flags_o,
  input logic              trap_req_o,
  input logic              addr_brk_inh_o
);
  AST_CARRY_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cry0_i ^ cry1_i) && !restore_i) |=> flags_o[F_AROV]); // R2
  AST_TRAP_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_o |-> trap_en_i); // R5
  AST_AFI_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_done_i && !afi_set_i && !restore_i) |=> !addr_brk_inh_o); // R8
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restore_i && !mode_wr_i && !insn_done_i) |=> ((flags_o & $past(flags_o)) == $past(flags_o))); // R9
  AST_RESTORE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> (flags_o == $past(restore_word_i[WORD_W-1 -: FLAG_N]))); // R10
  AST_CALL_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_i |=> (save_word_o[ADDR_W-1:0] == $past(call_addr_i) + ADDR_W'(1))); // R11
  AST_CALL_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_i |=> (save_word_o[WORD_W-1 -: FLAG_N] == $past(flags_o))); // R12
  AST_WORD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !call_i |=> $stable(save_word_o)); // R11
endmodule

bind stat_flags_unit stat_flags_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cry0_i         (cry0_i),
  .cry1_i         (cry1_i),
  .mode_wr_i      (mode_wr_i),
  .insn_done_i    (insn_done_i),
  .afi_set_i      (afi_set_i),
  .trap_en_i      (trap_en_i),
  .call_i         (call_i),
  .call_addr_i    (call_addr_i),
  .restore_i      (restore_i),
  .restore_word_i (restore_word_i),
  .save_word_o    (save_word_o),
  .flags_o        (flags_o),
  .trap_req_o     (trap_req_o),
  .addr_brk_inh_o (addr_brk_inh_o)
);

// File: tb/stat_flags_unit_tb_top.sv
module stat_flags_unit_tb_top;
  // flag positions per R2
  localparam logic [12:0] B_AROV = 13'h1000, B_CRY0 = 13'h0800, B_CRY1 = 13'h0400,
                          B_FOV  = 13'h0200, B_FPD  = 13'h0100, B_USER = 13'h0080,
                          B_UIO  = 13'h0040, B_PUB  = 13'h0020, B_AFI  = 13'h0010,
                          B_TRP2 = 13'h0008, B_TRP1 = 13'h0004, B_FXU  = 13'h0002,
                          B_DCK  = 13'h0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cry0, cry1, flt_ovf, exp_unf, div_chk, pdl_ovf, intr_mid;
  logic mode_wr, afi_set, insn_done, trap_en, call, restore;
  logic [2:0]  mode;
  logic [17:0] call_addr;
  logic [35:0] restore_word;
  logic [35:0] save_word;
  logic [12:0] flags;
  logic        trap_req, brk_inh;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  stat_flags_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cry0_i(cry0), .cry1_i(cry1),
    .flt_ovf_i(flt_ovf), .exp_unf_i(exp_unf), .div_chk_i(div_chk),
    .pdl_ovf_i(pdl_ovf), .intr_mid_i(intr_mid), .mode_wr_i(mode_wr),
    .mode_i(mode), .afi_set_i(afi_set), .insn_done_i(insn_done),
    .trap_en_i(trap_en), .call_i(call), .call_addr_i(call_addr),
    .restore_i(restore), .restore_word_i(restore_word),
    .save_word_o(save_word), .flags_o(flags), .trap_req_o(trap_req),
    .addr_brk_inh_o(brk_inh)
  );

  task automatic check(input string tag, input logic [35:0] got, input logic [35:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic idle_inputs();
    cry0 = 0; cry1 = 0; flt_ovf = 0; exp_unf = 0; div_chk = 0; pdl_ovf = 0;
    intr_mid = 0; mode_wr = 0; mode = 0; afi_set = 0; insn_done = 0;
    call = 0; call_addr = 0; restore = 0; restore_word = 0;
  endtask

  task automatic clear_flags();
    @(negedge clk); idle_inputs(); restore = 1; restore_word = '0;
    @(negedge clk); idle_inputs();
  endtask

  task automatic t_reset();
    check("R1 flags", 36'(flags), 36'h0);
    check("R1 word", save_word, 36'h0);
    check("R1 trap", 36'(trap_req), 36'h0);
    check("R1 inh", 36'(brk_inh), 36'h0);
  endtask

  task automatic t_carry();
    clear_flags();
    @(negedge clk); cry0 = 1;
    @(negedge clk); idle_inputs();
    check("R2 cry0 only", 36'(flags), 36'(B_AROV | B_CRY0 | B_TRP1));
    clear_flags();
    @(negedge clk); cry1 = 1;
    @(negedge clk); idle_inputs();
    check("R2 cry1 only", 36'(flags), 36'(B_AROV | B_CRY1 | B_TRP1));
    clear_flags();
    @(negedge clk); cry0 = 1; cry1 = 1;
    @(negedge clk); idle_inputs();
    check("R2 both carries", 36'(flags), 36'(B_CRY0 | B_CRY1));
  endtask

  task automatic t_float_div();
    clear_flags();
    @(negedge clk); exp_unf = 1;
    @(negedge clk); idle_inputs();
    check("R3 underflow", 36'(flags), 36'(B_FXU | B_FOV | B_AROV | B_TRP1));
    clear_flags();
    @(negedge clk); flt_ovf = 1;
    @(negedge clk); idle_inputs();
    check("R3 float ovf", 36'(flags), 36'(B_FOV | B_AROV | B_TRP1));
    clear_flags();
    @(negedge clk); div_chk = 1;
    @(negedge clk); idle_inputs();
    check("R3 divide check", 36'(flags), 36'(B_DCK | B_AROV | B_TRP1));
  endtask

  task automatic t_pushdown();
    clear_flags();
    @(negedge clk); pdl_ovf = 1;
    @(negedge clk); idle_inputs();
    check("R4 pushdown", 36'(flags), 36'(B_TRP2));
    clear_flags();
    @(negedge clk); pdl_ovf = 1; cry0 = 1;
    @(negedge clk); idle_inputs();
    check("R4 pushdown+ovf", 36'(flags), 36'(B_TRP2 | B_AROV | B_CRY0));
  endtask

  task automatic t_trap();
    clear_flags();
    trap_en = 1;
    @(negedge clk); pdl_ovf = 1; #1;
    check("R5 same-cycle req", 36'(trap_req), 36'h1);
    check("R5 flags not yet", 36'(flags), 36'h0);
    @(negedge clk); idle_inputs(); #1;
    check("R5 req held", 36'(trap_req), 36'h1);
    trap_en = 0; #1;
    check("R5 disabled", 36'(trap_req), 36'h0);
    clear_flags();
    trap_en = 1;
    @(negedge clk); div_chk = 1; restore = 1; restore_word = '0; #1;
    check("R10 restore masks trap", 36'(trap_req), 36'h0);
    @(negedge clk); idle_inputs();
    check("R10 restore beats event", 36'(flags), 36'h0);
    trap_en = 0;
  endtask

  task automatic t_fpd_mode();
    clear_flags();
    @(negedge clk); intr_mid = 1;
    @(negedge clk); idle_inputs();
    check("R6 first part done", 36'(flags), 36'(B_FPD));
    @(negedge clk); mode_wr = 1; mode = 3'b101;
    @(negedge clk); idle_inputs();
    check("R7 mode write", 36'(flags), 36'(B_FPD | B_USER | B_PUB));
    @(negedge clk); mode_wr = 1; mode = 3'b010;
    @(negedge clk); idle_inputs();
    check("R7 mode rewrite", 36'(flags), 36'(B_FPD | B_UIO));
  endtask

  task automatic t_afi();
    clear_flags();
    @(negedge clk); afi_set = 1;
    @(negedge clk); idle_inputs();
    check("R8 inhibit on", 36'(brk_inh), 36'h1);
    @(negedge clk); insn_done = 1; afi_set = 1;
    @(negedge clk); idle_inputs();
    check("R8 set beats done", 36'(brk_inh), 36'h1);
    @(negedge clk); insn_done = 1;
    @(negedge clk); idle_inputs();
    check("R8 inhibit cleared", 36'(brk_inh), 36'h0);
  endtask

  task automatic t_sticky();
    clear_flags();
    @(negedge clk); cry1 = 1; intr_mid = 1;
    @(negedge clk); idle_inputs();
    repeat (5) @(negedge clk);
    check("R9 sticky", 36'(flags), 36'(B_CRY1 | B_AROV | B_TRP1 | B_FPD));
  endtask

  task automatic t_restore();
    clear_flags();
    @(negedge clk); restore = 1; restore_word = {13'h15A5, 5'b11111, 18'h2ABCD};
    @(negedge clk); idle_inputs();
    check("R10 restore load", 36'(flags), 36'h15A5);
  endtask

  task automatic t_call();
    clear_flags();
    @(negedge clk); cry0 = 1;
    @(negedge clk); idle_inputs(); call = 1; call_addr = 18'h3FFFF; div_chk = 1;
    @(negedge clk); idle_inputs();
    check("R12 pre-event flags", save_word, {13'(B_AROV | B_CRY0 | B_TRP1), 5'b0, 18'h0});
    check("R12 event still lands", 36'(flags), 36'(B_AROV | B_CRY0 | B_TRP1 | B_DCK));
    @(negedge clk); cry1 = 1;
    @(negedge clk); idle_inputs();
    check("R11 word held", save_word, {13'(B_AROV | B_CRY0 | B_TRP1), 5'b0, 18'h0});
    @(negedge clk); call = 1; call_addr = 18'h00123;
    @(negedge clk); idle_inputs();
    check("R11 layout", save_word,
          {13'(B_AROV | B_CRY0 | B_CRY1 | B_TRP1 | B_DCK), 5'b0, 18'h00124});
  endtask

  initial begin
    idle_inputs();
    trap_en = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_carry();
    t_float_div();
    t_pushdown();
    t_trap();
    t_fpd_mode();
    t_afi();
    t_sticky();
    t_restore();
    t_call();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule